// File: doc/BRIEF.md
# Iterative radix-2 multiplier

This block multiplies two XLEN-bit operands by shift-and-add, one multiplier bit per clock. It can return either the low word or the high word of the double-width product. It covers four variants in a single loop:

- the low product;
- the high word with both operands signed;
- the high word with a signed first operand and an unsigned second operand;
- the high word with both operands unsigned.

The high accumulator is sign-extended when the first operand is signed. On the final step the multiplier bit can carry a negative weight, which is how a signed second operand is handled.

A requester raises `req_valid` together with operands and a variant code. It holds all of them steady until `ready` is seen high. The result is valid in that same cycle. When either operand is zero, the block skips the loop and answers immediately. Dropping `req_valid` abandons an operation in progress.

Top module: `iter_mul`

## Requirements
- R1: Variant code 2'b00 returns bits [XLEN-1:0] of the product of opa and opb, treated as signed numbers (the low word does not depend on signedness).
- R2: Variant code 2'b01 returns bits [2*XLEN-1:XLEN] of the signed×signed product.
- R3: Variant code 2'b10 returns bits [2*XLEN-1:XLEN] of signed opa times unsigned opb.
- R4: Variant code 2'b11 returns bits [2*XLEN-1:XLEN] of the unsigned×unsigned product.
- R5: Suppose a request is made from idle with both operands nonzero and is held. Then `ready` is low in the request cycle and for the next XLEN-2 cycles. It is high, with the result on `result`, in the cycle that begins XLEN-1 rising edges after the request cycle.
- R6: Suppose a request is made from idle with opa or opb equal to zero. Then `ready` is high in the same cycle and `result` is zero.
- R7: After an asynchronous active-low reset the block is idle. While idle with both operands nonzero, `ready` is low and `result` is zero; with a zero operand, `ready` is high.
- R8: Lowering `req_valid` during an operation returns the block to idle. A following request again takes the full R5 latency and gives a correct product.
- R9: If `req_valid` stays high through a completion, the block returns to idle on the next cycle. It then starts a new operation with the inputs present: `ready` is low in that cycle when both operands are nonzero, and the R5 latency applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request level, held until ready |
| variant | input | 2 | Product variant code (see R1-R4 encodings) |
| opa | input | XLEN | First operand (multiplicand) |
| opb | input | XLEN | Second operand (multiplier) |
| result | output | XLEN | Selected product word, valid while ready is high |
| ready | output | 1 | Result valid in this cycle |

## Verification
Both `ready` and `result` are combinational outputs, so their timing is fixed by edge counts:

- A request with a zero operand is answered in the cycle it is presented.
- A request with both operands nonzero is answered XLEN-1 rising edges later.
- With `req_valid` held, the cycle right after a completion is a fresh idle cycle.

The bench drives inputs on the falling edge and samples one time unit later. It counts the rising edges between the request and the first high `ready`, and compares that count with the expected latency. It compares the word shown in that cycle against a 2*XLEN-bit reference product computed from the variant's signedness.

// File: rtl/iter_mul_pkg.sv
package iter_mul_pkg;

   typedef enum logic [1:0] {
      MV_LOW   = 2'b00,
      MV_HI_SS = 2'b01,
      MV_HI_SU = 2'b10,
      MV_HI_UU = 2'b11
   } mul_variant_e;

   typedef enum logic {
      MS_IDLE = 1'b0,
      MS_RUN  = 1'b1
   } mul_state_e;

endpackage

// File: rtl/iter_mul_decode.sv
module iter_mul_decode
   import iter_mul_pkg::*;
(
   input  logic [1:0] variant,
   output logic       a_signed,
   output logic       b_signed,
   output logic       want_high
);

   mul_variant_e v;

   always_comb begin
      v         = mul_variant_e'(variant);
      a_signed  = (v != MV_HI_UU);
      b_signed  = (v == MV_LOW) || (v == MV_HI_SS);
      want_high = (v != MV_LOW);
   end

endmodule

// File: rtl/iter_mul_ctrl.sv
module iter_mul_ctrl
   import iter_mul_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit ZERO_SKIP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic ops_nonzero,
   output logic idle,
   output logic last,
   output logic ready,
   output logic upd
);

   localparam logic [XLEN-1:0] CNT_ONE  = {{(XLEN-1){1'b0}}, 1'b1};
   localparam logic [XLEN-1:0] CNT_INIT = CNT_ONE << (XLEN - 2);

   mul_state_e      state_q, state_n;
   logic [XLEN-1:0] cnt_q;
   logic            start;

   generate
      if (ZERO_SKIP) begin : g_skip
         assign start = ops_nonzero;
      end else begin : g_noskip
         logic unused_nz;
         assign unused_nz = ops_nonzero;
         assign start     = 1'b1;
      end
   endgenerate

   always_comb begin
      state_n = MS_IDLE;
      if (valid) begin
         case (state_q)
            MS_IDLE: state_n = start ? MS_RUN : MS_IDLE;
            MS_RUN:  state_n = cnt_q[0] ? MS_IDLE : MS_RUN;
            default: state_n = MS_IDLE;
         endcase
      end
   end

   assign idle  = (state_q == MS_IDLE);
   assign last  = cnt_q[0];
   assign ready = idle ? ~start : cnt_q[0];
   assign upd   = valid & ~ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MS_IDLE;
      end else begin
         state_q <= state_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (upd) begin
         cnt_q <= idle ? CNT_INIT : (cnt_q >> 1);
      end
   end

endmodule

// File: rtl/iter_mul_dp.sv
module iter_mul_dp #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd,
   input  logic            idle,
   input  logic            last,
   input  logic            a_signed,
   input  logic            b_signed,
   input  logic            want_high,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic [XLEN-1:0] result
);

   localparam int EW = XLEN + 1;

   logic [XLEN-1:0] hi_q, lo_q;
   logic [XLEN-1:0] acc_src, lo_src, hi_n, lo_n;
   logic [EW-1:0]   mcand, addend, acc_ext, sum;
   logic            mbit, neg_step;

   always_comb begin
      mcand    = {a_signed & opa[XLEN-1], opa};
      lo_src   = idle ? opb : lo_q;
      mbit     = lo_src[0];
      neg_step = ~idle & last & b_signed;
      if (!mbit) begin
         addend = '0;
      end else if (neg_step) begin
         addend = ~mcand + {{(EW-1){1'b0}}, 1'b1};
      end else begin
         addend = mcand;
      end
      acc_src = idle ? '0 : hi_q;
      acc_ext = {a_signed & acc_src[XLEN-1], acc_src};
      sum     = acc_ext + addend;
      hi_n    = sum[EW-1:1];
      lo_n    = {sum[0], lo_src[XLEN-1:1]};
      result  = idle ? '0 : (want_high ? hi_n : lo_n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (upd) begin
         hi_q <= hi_n;
         lo_q <= lo_n;
      end
   end

endmodule

// File: rtl/iter_mul.sv
module iter_mul #(
   parameter int XLEN      = 32,
   parameter bit ZERO_SKIP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [1:0]      variant,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic [XLEN-1:0] result,
   output logic            ready
);

   generate
      if (XLEN < 4 || XLEN > 64) begin : g_bad_xlen
         $error("iter_mul: XLEN must lie in 4..64");
      end
   endgenerate

   logic a_signed, b_signed, want_high;
   logic ctl_idle, ctl_last, ctl_upd;
   logic ops_nonzero;

   assign ops_nonzero = (|opa) & (|opb);

   iter_mul_decode u_decode (
      .variant   (variant),
      .a_signed  (a_signed),
      .b_signed  (b_signed),
      .want_high (want_high)
   );

   iter_mul_ctrl #(
      .XLEN      (XLEN),
      .ZERO_SKIP (ZERO_SKIP)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid       (req_valid),
      .ops_nonzero (ops_nonzero),
      .idle        (ctl_idle),
      .last        (ctl_last),
      .ready       (ready),
      .upd         (ctl_upd)
   );

   iter_mul_dp #(
      .XLEN (XLEN)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (ctl_upd),
      .idle      (ctl_idle),
      .last      (ctl_last),
      .a_signed  (a_signed),
      .b_signed  (b_signed),
      .want_high (want_high),
      .opa       (opa),
      .opb       (opb),
      .result    (result)
   );

endmodule

// File: rtl/iter_mul_chk.sv
module iter_mul_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            valid,
   input logic [XLEN-1:0] opa,
   input logic [XLEN-1:0] opb,
   input logic [XLEN-1:0] result,
   input logic            ready,
   input logic            idle
);

   localparam int CW = $clog2(XLEN) + 1;
   localparam logic [CW-1:0] DONE_AT = CW'(XLEN - 1);

   logic [CW-1:0] cyc;
   logic          nz;

   assign nz = (|opa) & (|opb);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc <= '0;
      end else if (!valid || ready) begin
         cyc <= '0;
      end else if (cyc != '1) begin
         cyc <= cyc + 1'b1;
      end
   end

   p_zero_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid && idle && !nz |-> ready && (result == '0));

   p_latency_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid && nz && (cyc < DONE_AT) |-> !ready);

   p_latency_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid && nz && (cyc == DONE_AT) |-> ready);

   p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> idle);

   p_restart_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid && ready && !idle |=> idle);

   p_idle_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
      idle && nz |-> !ready && (result == '0));

endmodule

bind iter_mul iter_mul_chk #(.XLEN(XLEN)) u_iter_mul_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .valid  (req_valid),
   .opa    (opa),
   .opb    (opb),
   .result (result),
   .ready  (ready),
   .idle   (ctl_idle)
);

// File: tb/tb_iter_mul.sv
module tb_iter_mul;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN       = 32;
   localparam int FULL_LAT   = XLEN - 1;
   localparam int WATCHDOG   = 20000;
   localparam int NVEC       = 10;

   localparam logic [63:0] VEC [NVEC] = '{
      {32'h0000_0007, 32'h0000_0006},
      {32'h8000_0000, 32'h8000_0000},
      {32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {32'h8000_0000, 32'hFFFF_FFFF},
      {32'h1234_5678, 32'h9ABC_DEF0},
      {32'h7FFF_FFFF, 32'h8000_0000},
      {32'hFFFF_FFFF, 32'h0000_0001},
      {32'hDEAD_BEEF, 32'hCAFE_F00D},
      {32'hFFFF_FFFE, 32'h7FFF_FFFF},
      {32'h0000_0001, 32'h8000_0001}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [1:0]      variant = 2'b00;
   logic [XLEN-1:0] opa = '0;
   logic [XLEN-1:0] opb = '0;
   logic [XLEN-1:0] result;
   logic            ready;

   int checks = 0;
   int failures = 0;

   iter_mul dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .variant   (variant),
      .opa       (opa),
      .opb       (opb),
      .result    (result),
      .ready     (ready)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] ref_mul(input logic [1:0] v,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
      logic signed [65:0] ea, eb, p;
      ea = (v == 2'b11) ? $signed({34'd0, a}) : $signed({{34{a[31]}}, a});
      eb = v[1] ? $signed({34'd0, b}) : $signed({{34{b[31]}}, b});
      p  = ea * eb;
      return (v == 2'b00) ? p[31:0] : p[63:32];
   endfunction

   function automatic string req_of(input logic [1:0] v);
      case (v)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_ready(output int lat);
      lat = 0;
      while (!ready && lat < 100) begin
         @(negedge clk);
         #1;
         lat++;
      end
   endtask

   task automatic do_op(input logic [1:0] v, input logic [31:0] a, input logic [31:0] b,
                        output int lat, output logic [31:0] res);
      @(negedge clk);
      req_valid = 1'b1;
      variant   = v;
      opa       = a;
      opb       = b;
      #1;
      wait_ready(lat);
      res = result;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int          lat, lat2;
      logic [31:0] res;

      // R7: reset state
      opa = 32'd5;
      opb = 32'd3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R7 idle ready low", {63'd0, ready}, 64'd0);
      chk("R7 idle result zero", {32'd0, result}, 64'd0);
      opa = 32'd0;
      #1;
      chk("R7 idle zero-operand ready", {63'd0, ready}, 64'd1);

      // R1-R4: vector table across all variants
      for (int i = 0; i < NVEC; i++) begin
         for (int v = 0; v < 4; v++) begin
            do_op(2'(v), VEC[i][63:32], VEC[i][31:0], lat, res);
            chk({req_of(2'(v)), " product"}, {32'd0, res},
                {32'd0, ref_mul(2'(v), VEC[i][63:32], VEC[i][31:0])});
            chk("R5 latency", 64'(lat), 64'(FULL_LAT));
         end
      end

      // R6: zero operands skip the loop
      do_op(2'b01, 32'd0, 32'h8000_0000, lat, res);
      chk("R6 zero opa latency", 64'(lat), 64'd0);
      chk("R6 zero opa result", {32'd0, res}, 64'd0);
      do_op(2'b11, 32'hFFFF_FFFF, 32'd0, lat, res);
      chk("R6 zero opb latency", 64'(lat), 64'd0);
      chk("R6 zero opb result", {32'd0, res}, 64'd0);
      do_op(2'b00, 32'd0, 32'd0, lat, res);
      chk("R6 both zero result", {32'd0, res}, 64'd0);

      // R8: abort by dropping valid, then a fresh operation
      @(negedge clk);
      req_valid = 1'b1;
      variant   = 2'b01;
      opa       = 32'h1357_9BDF;
      opb       = 32'h8642_0ECA;
      repeat (10) @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      do_op(2'b10, 32'hF000_000F, 32'hC000_0003, lat, res);
      chk("R8 post-abort latency", 64'(lat), 64'(FULL_LAT));
      chk("R8 post-abort product", {32'd0, res},
          {32'd0, ref_mul(2'b10, 32'hF000_000F, 32'hC000_0003)});

      // R9: valid held through completion restarts
      @(negedge clk);
      req_valid = 1'b1;
      variant   = 2'b11;
      opa       = 32'hAAAA_5555;
      opb       = 32'h0F0F_F0F0;
      #1;
      wait_ready(lat);
      chk("R9 first latency", 64'(lat), 64'(FULL_LAT));
      @(negedge clk);
      #1;
      chk("R9 ready low after held completion", {63'd0, ready}, 64'd0);
      wait_ready(lat2);
      chk("R9 second latency", 64'(lat2), 64'(FULL_LAT));
      chk("R9 second product", {32'd0, result},
          {32'd0, ref_mul(2'b11, 32'hAAAA_5555, 32'h0F0F_F0F0)});
      @(negedge clk);
      req_valid = 1'b0;

      // R7: reset in the middle of an operation
      @(negedge clk);
      req_valid = 1'b1;
      variant   = 2'b01;
      opa       = 32'h8000_0000;
      opb       = 32'h7FFF_FFFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R7 ready low after mid-run reset", {63'd0, ready}, 64'd0);
      wait_ready(lat);
      chk("R7 latency after mid-run reset", 64'(lat), 64'(FULL_LAT));
      chk("R7 product after mid-run reset", {32'd0, result},
          {32'd0, ref_mul(2'b01, 32'h8000_0000, 32'h7FFF_FFFF)});
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule